// File: doc/BRIEF.md
# Multi-Sector ECC Syndrome Corrector

After a flash page has been read into a 2048-byte buffer, this block checks the page one sector at a time. The page holds four sectors of 512 bytes. Each sector has a 32-bit check word stored with the data and a 32-bit check word recomputed from the data as it was read. The block XORs the two words to form a syndrome and sorts each sector into one of five kinds: erased, clean, damaged check word, single flipped data bit, or uncorrectable. When the syndrome points to one data bit, the block reads that byte from the buffer, inverts the bit and writes the byte back.

The host drives both sets of check words, pulses `start_i`, and waits for `done_o`. It then reads a summary status and two per-page counts. The check words must stay steady from `start_i` until `done_o`. The buffer port is a single byte-wide port with separate read and write strobes and a read latency of one cycle.

Top module: `ecc_sector_fixer`

## Requirements
- R1: A sector whose stored word is 0xFFFFFFFF counts as erased. It adds nothing to either count, and its buffer bytes are never read or written, whatever its computed word holds.
- R2: A sector whose stored and computed words are equal is clean. It adds to no count and causes no buffer access.
- R3: A syndrome with exactly one bit set adds one to the corrected count and causes no buffer access.
- R4: For any other nonzero syndrome s, let P = {s[19:16], s[31:24]} and Q = {s[3:0], s[15:8]}, both 12 bits. If P XOR Q equals 0xFFF, the block inverts bit Q[2:0] of the byte at buffer address sector*512 + Q[11:3]. It also adds one to the corrected count. No other byte changes.
- R5: A nonzero syndrome that meets neither the R3 rule nor the R4 rule adds one to the uncorrectable count and causes no buffer access.
- R6: `status_o` is 2 when the uncorrectable count is nonzero. Otherwise it is 1 when the corrected count is nonzero, and 0 when both counts are zero.
- R7: `fix_cnt_o` and `bad_cnt_o` give the number of corrected and uncorrectable sectors in the page. Their sum never exceeds four.
- R8: A bit fix takes two cycles. In the first, `buf_rd_o` is high with the address. In the second, `buf_wr_o` is high with the same address, and `buf_wdata_o` equals `buf_rdata_i` with one bit inverted. The two strobes are never high together.
- R9: Sectors are visited in order 0 to 3. `done_o` goes high 4 + 2F rising edges after the edge that samples `start_i`, where F is the number of bit fixes. It stays high for exactly one cycle.
- R10: After reset, `done_o`, `buf_rd_o` and `buf_wr_o` are low, and both counts and `status_o` are zero. From `done_o` until the next `start_i`, the counts and the status do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to check the page |
| stored_ecc_i | input | 128 | Stored check words; sector k in bits [32k+31:32k] |
| calc_ecc_i | input | 128 | Recomputed check words; same layout |
| buf_addr_o | output | 11 | Byte address into the page buffer |
| buf_rd_o | output | 1 | Buffer read strobe; data returns next cycle |
| buf_rdata_i | input | 8 | Byte read from the buffer |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Byte written to the buffer |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| fix_cnt_o | output | 3 | Corrected sector count |
| bad_cnt_o | output | 3 | Uncorrectable sector count |

## Verification
Each sector takes one evaluation cycle, and each bit fix adds a read cycle and a write cycle. The bench therefore predicts `done_o` at exactly 4 + 2F edges after the start edge, and it samples on falling edges only. It counts the edges it waits and compares that count with the prediction. It then checks that the pulse has dropped one cycle later. It compares the counts and status three cycles after that, so a value that drifts while idle is caught. The sweep covers all 625 ways of assigning the five sector kinds to four sectors. The buffer model runs with one cycle of read latency and is compared byte for byte against a copy kept by the bench.

// File: rtl/eccfix_pkg.sv
package eccfix_pkg;

  localparam int ECC_W  = 32;
  localparam int HALF_W = 12;
  localparam int BIT_W  = 3;
  localparam int OFF_W  = HALF_W - BIT_W;

  typedef enum logic [2:0] {
    SC_ERASED,
    SC_CLEAN,
    SC_ECCBIT,
    SC_DATABIT,
    SC_BAD
  } sect_class_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_EVAL,
    CS_READ,
    CS_WRITE,
    CS_DONE
  } ctrl_state_e;

  localparam logic [1:0] PG_OK    = 2'd0;
  localparam logic [1:0] PG_FIXED = 2'd1;
  localparam logic [1:0] PG_FAIL  = 2'd2;

endpackage

// File: rtl/eccfix_wordsel.sv
module eccfix_wordsel #(
  parameter int NUM_SECT = 4,
  parameter int W        = 32,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_SECT*W-1:0] flat_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [W-1:0]          word_o
);

  logic [W-1:0] words [NUM_SECT];

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_unpack
    assign words[g] = flat_i[g*W +: W];
  end

  assign word_o = words[idx_i];

endmodule

// File: rtl/eccfix_classify.sv
module eccfix_classify
  import eccfix_pkg::*;
(
  input  logic [ECC_W-1:0] stored_i,
  input  logic [ECC_W-1:0] calc_i,
  output sect_class_e      cls_o,
  output logic [OFF_W-1:0] byte_o,
  output logic [BIT_W-1:0] bit_o
);

  logic [ECC_W-1:0]  syn;
  logic [HALF_W-1:0] half_p;
  logic [HALF_W-1:0] half_q;
  logic              erased;
  logic              single;

  assign syn    = stored_i ^ calc_i;
  assign half_p = {syn[19:16], syn[31:24]};
  assign half_q = {syn[3:0], syn[15:8]};
  assign erased = &stored_i;
  assign single = ((syn & (syn - ECC_W'(1))) == '0);

  always_comb begin
    if (erased)                                cls_o = SC_ERASED;
    else if (syn == '0)                        cls_o = SC_CLEAN;
    else if (single)                           cls_o = SC_ECCBIT;
    else if ((half_p ^ half_q) == {HALF_W{1'b1}}) cls_o = SC_DATABIT;
    else                                       cls_o = SC_BAD;
  end

  assign byte_o = half_q[HALF_W-1:BIT_W];
  assign bit_o  = half_q[BIT_W-1:0];

endmodule

// File: rtl/eccfix_ctrl.sv
module eccfix_ctrl
  import eccfix_pkg::*;
#(
  parameter int NUM_SECT = 4,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 3,
  parameter int ADDR_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  sect_class_e       cls_i,
  input  logic [OFF_W-1:0]  byte_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [7:0]        rdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [7:0]        wdata_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [CNT_W-1:0]  fix_cnt_o,
  output logic [CNT_W-1:0]  bad_cnt_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SECT - 1);

  ctrl_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  fix_q, fix_d;
  logic [CNT_W-1:0]  bad_q, bad_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        mask_q, mask_d;
  logic              last;
  logic              en;

  assign last = (idx_q == LAST_IDX);
  assign en   = (state_q != CS_IDLE) || start_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fix_d   = fix_q;
    bad_d   = bad_q;
    addr_d  = addr_q;
    mask_d  = mask_q;
    unique case (state_q)
      CS_IDLE: begin
        if (start_i) begin
          state_d = CS_EVAL;
          idx_d   = '0;
          fix_d   = '0;
          bad_d   = '0;
        end
      end
      CS_EVAL: begin
        case (cls_i)
          SC_ECCBIT: fix_d = fix_q + CNT_W'(1);
          SC_DATABIT: begin
            fix_d  = fix_q + CNT_W'(1);
            addr_d = {idx_q, byte_i};
            mask_d = 8'(1) << bit_i;
          end
          SC_BAD: bad_d = bad_q + CNT_W'(1);
          default: ;
        endcase
        if (cls_i == SC_DATABIT) state_d = CS_READ;
        else if (last)           state_d = CS_DONE;
        else                     idx_d   = idx_q + IDX_W'(1);
      end
      CS_READ: state_d = CS_WRITE;
      CS_WRITE: begin
        if (last) state_d = CS_DONE;
        else begin
          state_d = CS_EVAL;
          idx_d   = idx_q + IDX_W'(1);
        end
      end
      CS_DONE: state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      idx_q   <= '0;
      fix_q   <= '0;
      bad_q   <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
    end else if (en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fix_q   <= fix_d;
      bad_q   <= bad_d;
      addr_q  <= addr_d;
      mask_q  <= mask_d;
    end
  end

  assign idx_o     = idx_q;
  assign addr_o    = addr_q;
  assign rd_o      = (state_q == CS_READ);
  assign wr_o      = (state_q == CS_WRITE);
  assign wdata_o   = rdata_i ^ mask_q;
  assign done_o    = (state_q == CS_DONE);
  assign fix_cnt_o = fix_q;
  assign bad_cnt_o = bad_q;

  always_comb begin
    if (bad_q != '0)      status_o = PG_FAIL;
    else if (fix_q != '0) status_o = PG_FIXED;
    else                  status_o = PG_OK;
  end

endmodule

// File: rtl/ecc_sector_fixer.sv
module ecc_sector_fixer
  import eccfix_pkg::*;
#(
  parameter int NUM_SECT = 4,
  localparam int IDX_W   = $clog2(NUM_SECT),
  localparam int ADDR_W  = IDX_W + OFF_W,
  localparam int CNT_W   = $clog2(NUM_SECT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [NUM_SECT*ECC_W-1:0] stored_ecc_i,
  input  logic [NUM_SECT*ECC_W-1:0] calc_ecc_i,
  output logic [ADDR_W-1:0]         buf_addr_o,
  output logic                      buf_rd_o,
  input  logic [7:0]                buf_rdata_i,
  output logic                      buf_wr_o,
  output logic [7:0]                buf_wdata_o,
  output logic                      done_o,
  output logic [1:0]                status_o,
  output logic [CNT_W-1:0]          fix_cnt_o,
  output logic [CNT_W-1:0]          bad_cnt_o
);

  logic [IDX_W-1:0] idx;
  logic [ECC_W-1:0] cur_stored;
  logic [ECC_W-1:0] cur_calc;
  sect_class_e      cls;
  logic [OFF_W-1:0] byte_off;
  logic [BIT_W-1:0] bit_sel;

  eccfix_wordsel #(.NUM_SECT(NUM_SECT), .W(ECC_W), .IDX_W(IDX_W)) u_sel_stored (
    .flat_i (stored_ecc_i),
    .idx_i  (idx),
    .word_o (cur_stored)
  );

  eccfix_wordsel #(.NUM_SECT(NUM_SECT), .W(ECC_W), .IDX_W(IDX_W)) u_sel_calc (
    .flat_i (calc_ecc_i),
    .idx_i  (idx),
    .word_o (cur_calc)
  );

  eccfix_classify u_classify (
    .stored_i (cur_stored),
    .calc_i   (cur_calc),
    .cls_o    (cls),
    .byte_o   (byte_off),
    .bit_o    (bit_sel)
  );

  eccfix_ctrl #(
    .NUM_SECT (NUM_SECT),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cls_i     (cls),
    .byte_i    (byte_off),
    .bit_i     (bit_sel),
    .rdata_i   (buf_rdata_i),
    .idx_o     (idx),
    .addr_o    (buf_addr_o),
    .rd_o      (buf_rd_o),
    .wr_o      (buf_wr_o),
    .wdata_o   (buf_wdata_o),
    .done_o    (done_o),
    .status_o  (status_o),
    .fix_cnt_o (fix_cnt_o),
    .bad_cnt_o (bad_cnt_o)
  );

endmodule

// File: rtl/ecc_sector_fixer_chk.sv
module ecc_sector_fixer_chk #(
  parameter int NUM_SECT = 4,
  parameter int ADDR_W   = 11,
  parameter int CNT_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic              buf_rd_o,
  input logic [7:0]        buf_rdata_i,
  input logic              buf_wr_o,
  input logic [7:0]        buf_wdata_o,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic [CNT_W-1:0]  fix_cnt_o,
  input logic [CNT_W-1:0]  bad_cnt_o
);

  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (done_o)  held_q <= 1'b1;
    else if (start_i) held_q <= 1'b0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) buf_rd_o |=> buf_wr_o); // R8
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) buf_wr_o |-> $past(buf_rd_o)); // R8
  AST_NO_RDWR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(buf_rd_o && buf_wr_o)); // R8
  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n) buf_wr_o |-> buf_addr_o == $past(buf_addr_o)); // R4
  AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n) buf_wr_o |-> $countones(buf_wdata_o ^ buf_rdata_i) == 1); // R4
  AST_TALLY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (32'(fix_cnt_o) + 32'(bad_cnt_o)) <= NUM_SECT); // R7
  AST_STATUS_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (bad_cnt_o != '0) |-> status_o == 2'd2); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (held_q && !start_i) |=> ($stable(fix_cnt_o) && $stable(bad_cnt_o) && $stable(status_o))); // R10

endmodule

bind ecc_sector_fixer ecc_sector_fixer_chk #(
  .NUM_SECT (NUM_SECT),
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .buf_addr_o  (buf_addr_o),
  .buf_rd_o    (buf_rd_o),
  .buf_rdata_i (buf_rdata_i),
  .buf_wr_o    (buf_wr_o),
  .buf_wdata_o (buf_wdata_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .fix_cnt_o   (fix_cnt_o),
  .bad_cnt_o   (bad_cnt_o)
);

// File: tb/ecc_sector_fixer_bench.sv
module ecc_sector_fixer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int PAGE = 2048;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [127:0]  stored_ecc_i;
  logic [127:0]  calc_ecc_i;
  logic [10:0]   buf_addr_o;
  logic          buf_rd_o;
  logic [7:0]    buf_rdata_i;
  logic          buf_wr_o;
  logic [7:0]    buf_wdata_o;
  logic          done_o;
  logic [1:0]    status_o;
  logic [2:0]    fix_cnt_o;
  logic [2:0]    bad_cnt_o;

  logic [7:0] mem     [PAGE];
  logic [7:0] exp_mem [PAGE];
  int nrd_tot, nwr_tot, seq_err_tot;
  logic rd_prev;
  int nchk, nerr;

  ecc_sector_fixer u_ecc_sector_fixer (
    .clk, .rst_n, .start_i, .stored_ecc_i, .calc_ecc_i,
    .buf_addr_o, .buf_rd_o, .buf_rdata_i, .buf_wr_o, .buf_wdata_o,
    .done_o, .status_o, .fix_cnt_o, .bad_cnt_o
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'((a >> 8) * 53);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) mem[i] <= pat(i);
      nrd_tot <= 0; nwr_tot <= 0; seq_err_tot <= 0; rd_prev <= 1'b0;
    end else begin
      rd_prev <= buf_rd_o;
      if (buf_rd_o) begin
        buf_rdata_i <= mem[buf_addr_o];
        nrd_tot <= nrd_tot + 1;
      end
      if (buf_wr_o) begin
        mem[buf_addr_o] <= buf_wdata_o;
        nwr_tot <= nwr_tot + 1;
        if (!rd_prev) seq_err_tot <= seq_err_tot + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // syndrome that, by the R4 rule, points at byte b and bit t
  function automatic logic [31:0] mk_syn(input logic [8:0] b, input logic [2:0] t);
    logic [11:0] q, p;
    q = {b, t};
    p = ~q;
    return {p[7:0], 4'h0, p[11:8], q[7:0], 4'h0, q[11:8]};
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    nchk = 0; nerr = 0;
    rst_n = 1'b0; start_i = 1'b0;
    stored_ecc_i = '0; calc_ecc_i = '0;
    for (int i = 0; i < PAGE; i++) exp_mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!done_o && !buf_rd_o && !buf_wr_o, "R10", {done_o, buf_rd_o, buf_wr_o}, 0);
    chk(fix_cnt_o == 0 && bad_cnt_o == 0 && status_o == 0, "R10",
        {fix_cnt_o, bad_cnt_o, status_o}, 0);

    for (int combo = 0; combo < 625; combo++) begin
      int pw, nfix, nbad, nflip, lat, rd0, wr0, mm, est;
      logic [2:0] f_now; logic [2:0] b_now; logic [1:0] s_now;
      pw = 1; nfix = 0; nbad = 0; nflip = 0;
      for (int s = 0; s < NS; s++) begin
        int c;
        logic [31:0] base, syn;
        c = (combo / pw) % 5;
        pw = pw * 5;
        base = 32'h1357_9BDF ^ (32'(combo) << 4) ^ 32'(s);
        case (c)
          0: begin // R1 erased: computed word arbitrary, even decodable
            stored_ecc_i[s*32 +: 32] = 32'hFFFF_FFFF;
            calc_ecc_i[s*32 +: 32]   = 32'hFFFF_FFFF ^ mk_syn(9'(combo), 3'(s));
          end
          1: begin // R2 clean
            stored_ecc_i[s*32 +: 32] = base;
            calc_ecc_i[s*32 +: 32]   = base;
          end
          2: begin // R3 single-bit syndrome
            syn = 32'(1) << ((combo + 7 * s) % 32);
            stored_ecc_i[s*32 +: 32] = base;
            calc_ecc_i[s*32 +: 32]   = base ^ syn;
            nfix++;
          end
          3: begin // R4 data bit fix
            int b, t;
            b = (combo * 37 + s * 101) % 512;
            t = (combo + 3 * s) % 8;
            syn = mk_syn(9'(b), 3'(t));
            stored_ecc_i[s*32 +: 32] = base;
            calc_ecc_i[s*32 +: 32]   = base ^ syn;
            exp_mem[s*512 + b] = exp_mem[s*512 + b] ^ (8'(1) << t);
            nfix++; nflip++;
          end
          default: begin // R5 two-bit, halves not complementary
            syn = 32'h3 << ((combo + s) % 8);
            stored_ecc_i[s*32 +: 32] = base;
            calc_ecc_i[s*32 +: 32]   = base ^ syn;
            nbad++;
          end
        endcase
      end
      rd0 = nrd_tot; wr0 = nwr_tot;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 64) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == 4 + 2 * nflip, "R9 latency", lat, 4 + 2 * nflip);
      chk(fix_cnt_o == 3'(nfix), "R7 fix count", fix_cnt_o, nfix);
      chk(bad_cnt_o == 3'(nbad), "R7 bad count", bad_cnt_o, nbad);
      est = (nbad != 0) ? 2 : (nfix != 0) ? 1 : 0;
      chk(status_o == 2'(est), "R6 status", status_o, est);
      f_now = fix_cnt_o; b_now = bad_cnt_o; s_now = status_o;
      @(negedge clk);
      chk(!done_o, "R9 pulse width", done_o, 0);
      repeat (3) @(negedge clk);
      chk(fix_cnt_o == f_now && bad_cnt_o == b_now && status_o == s_now, "R10 hold",
          {fix_cnt_o, bad_cnt_o, status_o}, {f_now, b_now, s_now});
      // R1 R2 R3 R5: only R4 sectors touch the buffer
      chk(nrd_tot - rd0 == nflip && nwr_tot - wr0 == nflip, "R8 accesses",
          (nrd_tot - rd0) + (nwr_tot - wr0), 2 * nflip);
      mm = 0;
      for (int i = 0; i < PAGE; i++) if (mem[i] !== exp_mem[i]) mm++;
      chk(mm == 0, "R4 buffer bytes", mm, 0);
    end
    chk(seq_err_tot == 0, "R8 write follows read", seq_err_tot, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule